// File: doc/BRIEF.md
# Controller Reset Handshake Gate

This block owns the global reset of a serial audio link controller. Software controls it through a memory-mapped register port with byte enables. Writing 0 to the run bit of the global control register starts a timed entry into reset. The link reset output goes active and the internal soft reset is raised at once. After a fixed number of clocks the run bit reads 0. Writing 1 starts the reverse sequence. The link reset is released first, and the run bit reads 1 only after a fixed settling time, when the controller is ready.

While the run bit reads 0, the block acts as a write gate for the whole register space. Writes to every other register are dropped, and reads of every other register return zero. The one exception is the global control register, which accepts any write that has byte lane 0 enabled. The block also holds a small wake-enable mask, one bit per serial data input. Only power-on reset clears this mask. While the controller is in reset, the block raises a wake request whenever an enabled input is high.

Writes to registers outside this block are passed through a plain forwarded write strobe. Reads of those registers come back on an external read-data input. Both paths are single-cycle register accesses with no handshake, so back-pressure does not apply.

Top module: `ctl_reset_gate`

## Requirements
- R1: After power-on or hardware reset, the run status (`ctl_active`) is 0, `link_rst_n` is 0 and `soft_rst` is 1. They stay so until software writes 1 to the run bit.
- R2: The run bit is bit 0 of the global control register at byte address 0x08, in byte lane 0. A write of 1 to it, sampled at edge t, releases `link_rst_n` after edge t+1. `ctl_active` rises and `soft_rst` falls after edge t+1+EXIT_CYC (default 4).
- R3: A write of 0 to the run bit, sampled at edge t, drives `link_rst_n` to 0 and `soft_rst` to 1 after edge t+1. `ctl_active` stays 1 until it falls after edge t+1+ENTER_CYC (default 8).
- R4: A write to the global control register with `wr_be[0]` = 0 has no effect on the run bit.
- R5: While `ctl_active` is 0, writes to any address other than 0x08 are dropped. `fwd_wr_en` stays 0 and the wake mask is unchanged. While it is 1, a write to an address other than 0x08 and 0x0C raises `fwd_wr_en` in the same cycle, with the address, data and byte enables passed through.
- R6: A read of 0x08 returns the run status in bit 0 and zeros in all other bits. While `ctl_active` is 0, a read of any other address returns 0. While it is 1, a read of 0x0C returns the wake register, and any other address returns `ext_rd_data`.
- R7: The wake register is at 0x0C. Bits 2:0 are a read/write mask, with bit i for serial input i, written only when `wr_be[0]` = 1. Bits 15:3 and above read as zero.
- R8: Only `por_n` clears the wake mask. It survives `rst_n` and every soft reset sequence.
- R9: `wake_req` is 1 exactly when `ctl_active` is 0 and some input `sdi[i]` is high while mask bit i is set.
- R10: A run-bit write that arrives during a sequence is latched. It takes effect once the sequence completes, and the last value written wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, async; clears everything including the wake mask |
| rst_n | input | 1 | Hardware reset, active low, async; clears everything except the wake mask |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/8 | Write byte enables |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Read data, combinational from `rd_addr` |
| ext_rd_data | input | DATA_W | Read data of the registers outside this block |
| sdi | input | N_SDI | Serial data input levels for wake detection |
| fwd_wr_en | output | 1 | Gated write strobe to the other registers |
| fwd_wr_addr | output | ADDR_W | Forwarded write address |
| fwd_wr_data | output | DATA_W | Forwarded write data |
| fwd_wr_be | output | DATA_W/8 | Forwarded byte enables |
| link_rst_n | output | 1 | Link reset, active low |
| soft_rst | output | 1 | Internal controller soft reset, active high |
| ctl_active | output | 1 | Completed run status, the value the run bit reads |
| wake_req | output | 1 | Wake request |

## Verification
The assertions check on every cycle the properties that can be stated as invariants:
- The run status only falls after exactly ENTER_CYC cycles of entry sequencing, and only rises after EXIT_CYC cycles with the link released.
- The soft reset is held whenever status is 0 or the link is in reset.
- No forwarded write and no wake request appear in the wrong state.
- Non-control reads return zero while the controller is in reset.

Some behaviour can only be shown by the bench scenarios:
- A write to the run bit is latched during a sequence.
- A write without byte lane 0 is ignored.
- The wake mask survives hardware reset but not power-on reset.
- The total cycle counts from a write to the status change.

// File: rtl/crg_pkg.sv
`timescale 1ns/1ps
package crg_pkg;
  // Sequencer phases. HELD and RISE read as not running; LIVE and FALL read as running.
  typedef enum logic [1:0] {
    ST_HELD = 2'd0,
    ST_RISE = 2'd1,
    ST_LIVE = 2'd2,
    ST_FALL = 2'd3
  } crg_state_e;
endpackage

// File: rtl/crg_seq.sv
`timescale 1ns/1ps
module crg_seq
  import crg_pkg::*;
#(
  parameter int ENTER_CYC = 8,
  parameter int EXIT_CYC  = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req_wr,
  input  logic req_val,
  output logic ctl_active,
  output logic link_rst_n,
  output logic soft_rst
);
  localparam int MAXC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ENTER_LAST = CW'(ENTER_CYC - 1);
  localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_CYC - 1);

  crg_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic want_q;

  // Latest requested run value; kept even while a sequence is in flight.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) want_q <= 1'b0;
    else if (req_wr) want_q <= req_val;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_HELD: if (want_q) begin st_d = ST_RISE; cnt_d = '0; end
      ST_RISE: if (cnt_q == EXIT_LAST) st_d = ST_LIVE;
               else cnt_d = cnt_q + CW'(1);
      ST_LIVE: if (!want_q) begin st_d = ST_FALL; cnt_d = '0; end
      ST_FALL: if (cnt_q == ENTER_LAST) st_d = ST_HELD;
               else cnt_d = cnt_q + CW'(1);
      default: st_d = ST_HELD;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q  <= ST_HELD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign ctl_active = (st_q == ST_LIVE) || (st_q == ST_FALL);
  assign link_rst_n = (st_q == ST_RISE) || (st_q == ST_LIVE);
  assign soft_rst   = (st_q != ST_LIVE);
endmodule

// File: rtl/crg_wake.sv
`timescale 1ns/1ps
module crg_wake #(
  parameter int N_SDI = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_stb,
  input  logic [N_SDI-1:0] wr_bits,
  input  logic             active,
  input  logic [N_SDI-1:0] sdi,
  output logic [N_SDI-1:0] mask,
  output logic             wake_req
);
  logic [N_SDI-1:0] hit;

  // One resume-domain enable flop per serial input.
  for (genvar i = 0; i < N_SDI; i++) begin : g_lane
    logic en_q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) en_q <= 1'b0;
      else if (wr_stb) en_q <= wr_bits[i];
    end
    assign mask[i] = en_q;
    assign hit[i]  = en_q & sdi[i];
  end

  assign wake_req = ~active & (|hit);
endmodule

// File: rtl/crg_gate.sv
`timescale 1ns/1ps
module crg_gate #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 32,
  parameter int              N_SDI     = 3,
  parameter logic [ADDR_W-1:0] GCTL_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] WAKE_ADDR = 8'h0C
) (
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]   ext_rd_data,
  input  logic                active,
  input  logic [N_SDI-1:0]    mask,
  output logic                ctl_wr,
  output logic                ctl_val,
  output logic                wake_wr,
  output logic [N_SDI-1:0]    wake_bits,
  output logic                fwd_wr_en,
  output logic [ADDR_W-1:0]   fwd_wr_addr,
  output logic [DATA_W-1:0]   fwd_wr_data,
  output logic [DATA_W/8-1:0] fwd_wr_be,
  output logic [DATA_W-1:0]   rd_data
);
  logic hit_ctl, hit_wake;

  assign hit_ctl  = (wr_addr == GCTL_ADDR);
  assign hit_wake = (wr_addr == WAKE_ADDR);

  // Global control: only lane 0 matters, accepted in any state.
  assign ctl_wr  = wr_en & hit_ctl & wr_be[0];
  assign ctl_val = wr_data[0];

  // Everything else is blocked until the controller reports running.
  assign wake_wr   = wr_en & hit_wake & wr_be[0] & active;
  assign wake_bits = wr_data[N_SDI-1:0];

  assign fwd_wr_en   = wr_en & active & ~hit_ctl & ~hit_wake;
  assign fwd_wr_addr = wr_addr;
  assign fwd_wr_data = wr_data;
  assign fwd_wr_be   = wr_be;

  always_comb begin
    rd_data = '0;
    if (rd_addr == GCTL_ADDR) rd_data[0] = active;
    else if (active) rd_data = (rd_addr == WAKE_ADDR) ? DATA_W'(mask) : ext_rd_data;
  end
endmodule

// File: rtl/ctl_reset_gate.sv
`timescale 1ns/1ps
module ctl_reset_gate #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                N_SDI     = 3,
  parameter int                ENTER_CYC = 8,
  parameter int                EXIT_CYC  = 4,
  parameter logic [ADDR_W-1:0] GCTL_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] WAKE_ADDR = 8'h0C
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [DATA_W-1:0]   ext_rd_data,
  input  logic [N_SDI-1:0]    sdi,
  output logic                fwd_wr_en,
  output logic [ADDR_W-1:0]   fwd_wr_addr,
  output logic [DATA_W-1:0]   fwd_wr_data,
  output logic [DATA_W/8-1:0] fwd_wr_be,
  output logic                link_rst_n,
  output logic                soft_rst,
  output logic                ctl_active,
  output logic                wake_req
);
  logic             seq_arst_n;
  logic             ctl_wr, ctl_val, wake_wr;
  logic [N_SDI-1:0] wake_bits, mask;

  assign seq_arst_n = por_n & rst_n;

  crg_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SDI(N_SDI),
    .GCTL_ADDR(GCTL_ADDR), .WAKE_ADDR(WAKE_ADDR)
  ) u_gate (
    .wr_addr(wr_addr), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
    .rd_addr(rd_addr), .ext_rd_data(ext_rd_data), .active(ctl_active), .mask(mask),
    .ctl_wr(ctl_wr), .ctl_val(ctl_val), .wake_wr(wake_wr), .wake_bits(wake_bits),
    .fwd_wr_en(fwd_wr_en), .fwd_wr_addr(fwd_wr_addr), .fwd_wr_data(fwd_wr_data),
    .fwd_wr_be(fwd_wr_be), .rd_data(rd_data)
  );

  crg_seq #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_seq (
    .clk(clk), .arst_n(seq_arst_n), .req_wr(ctl_wr), .req_val(ctl_val),
    .ctl_active(ctl_active), .link_rst_n(link_rst_n), .soft_rst(soft_rst)
  );

  crg_wake #(.N_SDI(N_SDI)) u_wake (
    .clk(clk), .por_n(por_n), .wr_stb(wake_wr), .wr_bits(wake_bits),
    .active(ctl_active), .sdi(sdi), .mask(mask), .wake_req(wake_req)
  );
endmodule

// File: rtl/crg_chk.sv
`timescale 1ns/1ps
module crg_chk #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                N_SDI     = 3,
  parameter int                ENTER_CYC = 8,
  parameter int                EXIT_CYC  = 4,
  parameter logic [ADDR_W-1:0] GCTL_ADDR = 8'h08
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              ctl_active,
  input logic              link_rst_n,
  input logic              soft_rst,
  input logic              wake_req,
  input logic [N_SDI-1:0]  sdi,
  input logic              fwd_wr_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  logic        arst_n;
  logic [15:0] ent_cnt, ext_cnt;

  assign arst_n = por_n & rst_n;

  // Window counters: cycles spent running-with-soft-reset, and link-up-but-not-ready.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ent_cnt <= '0;
      ext_cnt <= '0;
    end else begin
      ent_cnt <= (ctl_active && soft_rst) ? ent_cnt + 16'd1 : 16'd0;
      ext_cnt <= (link_rst_n && !ctl_active) ? ext_cnt + 16'd1 : 16'd0;
    end
  end

  assert_enter_time_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(ctl_active) |-> (ent_cnt == 16'(ENTER_CYC)))
    else $error("status fell after wrong entry time");

  assert_exit_time_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(ctl_active) |-> (ext_cnt == 16'(EXIT_CYC)) && link_rst_n)
    else $error("status rose after wrong exit time");

  assert_link_first_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(link_rst_n) |-> !ctl_active)
    else $error("link released while already running");

  assert_held_in_reset_R1: assert property (@(posedge clk) disable iff (!arst_n)
    !ctl_active |-> soft_rst)
    else $error("soft reset dropped while status reads 0");

  assert_link_implies_soft_R3: assert property (@(posedge clk) disable iff (!arst_n)
    !link_rst_n |-> soft_rst)
    else $error("link in reset without soft reset");

  assert_no_fwd_in_reset_R5: assert property (@(posedge clk) disable iff (!arst_n)
    fwd_wr_en |-> ctl_active)
    else $error("write forwarded while in reset");

  assert_read_zero_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (!ctl_active && rd_addr != GCTL_ADDR) |-> (rd_data == '0))
    else $error("nonzero read while in reset");

  assert_wake_cond_R9: assert property (@(posedge clk) disable iff (!arst_n)
    wake_req |-> (!ctl_active && (sdi != '0)))
    else $error("wake request in wrong state");
endmodule

bind ctl_reset_gate crg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SDI(N_SDI),
  .ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC), .GCTL_ADDR(GCTL_ADDR)
) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .ctl_active(ctl_active),
  .link_rst_n(link_rst_n), .soft_rst(soft_rst), .wake_req(wake_req), .sdi(sdi),
  .fwd_wr_en(fwd_wr_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_ctl_reset_gate.sv
`timescale 1ns/1ps
module tb_ctl_reset_gate;
  localparam logic [7:0] GCTL  = 8'h08;
  localparam logic [7:0] WAKE  = 8'h0C;
  localparam logic [7:0] OTHER = 8'h20;
  localparam int ENTER = 8;
  localparam int EXIT  = 4;
  localparam logic [31:0] EXT = 32'hA5A5_0F0F;

  logic clk = 1'b0;
  logic por_n, rst_n, wr_en;
  logic [7:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [3:0] wr_be, fwd_wr_be;
  logic [2:0] sdi;
  logic fwd_wr_en, link_rst_n, soft_rst, ctl_active, wake_req;
  logic [7:0] fwd_wr_addr;
  logic [31:0] fwd_wr_data;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0, done = 1'b0;
  logic last_fwd;

  always #4 clk = ~clk;

  ctl_reset_gate dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_rd_data(EXT), .sdi(sdi), .fwd_wr_en(fwd_wr_en), .fwd_wr_addr(fwd_wr_addr),
    .fwd_wr_data(fwd_wr_data), .fwd_wr_be(fwd_wr_be), .link_rst_n(link_rst_n),
    .soft_rst(soft_rst), .ctl_active(ctl_active), .wake_req(wake_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 held, 1 link up waiting, 2 running, 3 draining.
  int m_phase = 0, m_cnt = 0;
  bit m_want = 1'b0;
  logic [2:0] m_mask = 3'b000;

  always @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n) begin
      m_phase <= 0; m_cnt <= 0; m_want <= 1'b0; m_mask <= 3'b000;
    end else if (!rst_n) begin
      m_phase <= 0; m_cnt <= 0; m_want <= 1'b0;
    end else begin
      if (wr_en && wr_addr == GCTL && wr_be[0]) m_want <= wr_data[0];
      if (wr_en && wr_addr == WAKE && wr_be[0] && m_phase >= 2) m_mask <= wr_data[2:0];
      if (m_phase == 0 && m_want) begin m_phase <= 1; m_cnt <= 0; end
      else if (m_phase == 1) begin
        if (m_cnt == EXIT - 1) m_phase <= 2; else m_cnt <= m_cnt + 1;
      end else if (m_phase == 2 && !m_want) begin m_phase <= 3; m_cnt <= 0; end
      else if (m_phase == 3) begin
        if (m_cnt == ENTER - 1) m_phase <= 0; else m_cnt <= m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (cmp_on && !done) begin
      logic e_act, e_fwd;
      logic [31:0] e_rd;
      e_act = (m_phase >= 2);
      e_fwd = wr_en && e_act && wr_addr != GCTL && wr_addr != WAKE;
      if (rd_addr == GCTL) e_rd = {31'd0, e_act};
      else if (!e_act) e_rd = 32'd0;
      else if (rd_addr == WAKE) e_rd = {29'd0, m_mask};
      else e_rd = EXT;
      check("R2 R3 ctl_active", {31'd0, ctl_active}, {31'd0, e_act});
      check("R2 R3 link_rst_n", {31'd0, link_rst_n}, {31'd0, (m_phase == 1 || m_phase == 2)});
      check("R2 R3 soft_rst", {31'd0, soft_rst}, {31'd0, (m_phase != 2)});
      check("R9 wake_req", {31'd0, wake_req}, {31'd0, (!e_act && |(m_mask & sdi))});
      check("R5 fwd_wr_en", {31'd0, fwd_wr_en}, {31'd0, e_fwd});
      if (e_fwd) check("R5 fwd data", fwd_wr_data ^ {24'd0, fwd_wr_addr} ^ {28'd0, fwd_wr_be},
                       wr_data ^ {24'd0, wr_addr} ^ {28'd0, wr_be});
      check("R6 rd_data", rd_data, e_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    #1 last_fwd = fwd_wr_en;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_be = '0; wr_addr = 8'h00;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1 check(req, rd_data, exp);
  endtask

  task automatic wait_active(input logic v, output int n);
    n = 0;
    while (ctl_active !== v && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic bring_up();
    int n;
    wr(GCTL, 32'd1, 4'b0001);
    wait_active(1'b1, n);
  endtask

  initial begin
    int n;
    por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    wr_be = '0; rd_addr = OTHER; sdi = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;

    // R1 reset state and staying in reset
    check("R1 status after reset", {31'd0, ctl_active}, 32'd0);
    check("R1 link held", {31'd0, link_rst_n}, 32'd0);
    check("R1 soft reset", {31'd0, soft_rst}, 32'd1);
    repeat (20) @(negedge clk);
    check("R1 still in reset", {31'd0, ctl_active}, 32'd0);

    // R5 writes dropped in reset
    wr(WAKE, 32'h7, 4'hF);
    wr(OTHER, 32'h1234_5678, 4'hF);
    check("R5 no forward in reset", {31'd0, last_fwd}, 32'd0);

    // R4 missing lane 0
    wr(GCTL, 32'hFFFF_FFFF, 4'b1110);
    repeat (10) @(negedge clk);
    check("R4 lane0 off ignored", {31'd0, ctl_active}, 32'd0);

    // R2 exit timing
    wr(GCTL, 32'd1, 4'b0001);
    wait_active(1'b1, n);
    check("R2 cycles to running", n, 32'd5);
    rd_chk("R2 run bit reads 1", GCTL, 32'd1);
    rd_chk("R5 wake write in reset dropped", WAKE, 32'd0);

    // R7 wake register
    wr(WAKE, 32'hFFFF_FFFF, 4'b0011);
    rd_chk("R7 mask bits only", WAKE, 32'h7);
    wr(WAKE, 32'h0, 4'b0010);
    rd_chk("R7 lane0 required", WAKE, 32'h7);
    rd_chk("R6 ext read running", OTHER, EXT);
    wr(OTHER, 32'hCAFE_0001, 4'b0101);
    check("R5 forward when running", {31'd0, last_fwd}, 32'd1);
    sdi = 3'b111;
    @(negedge clk); #1 check("R9 no wake while running", {31'd0, wake_req}, 32'd0);

    // R3 entry timing
    sdi = 3'b000;
    wr(GCTL, 32'd0, 4'b1111);
    wait_active(1'b0, n);
    check("R3 cycles to reset", n, 32'd9);
    rd_chk("R6 other reads zero", OTHER, 32'd0);
    rd_chk("R6 run bit reads 0", GCTL, 32'd0);
    sdi = 3'b010;
    @(negedge clk); #1 check("R9 wake on enabled input", {31'd0, wake_req}, 32'd1);
    sdi = 3'b000;
    @(negedge clk); #1 check("R9 no wake idle", {31'd0, wake_req}, 32'd0);

    // R8 mask survives rst_n, cleared by por_n
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    bring_up();
    rd_chk("R8 mask kept over rst_n", WAKE, 32'h7);
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk); por_n = 1'b1;
    check("R8 por returns to reset", {31'd0, ctl_active}, 32'd0);
    bring_up();
    rd_chk("R8 mask cleared by por_n", WAKE, 32'd0);

    // R10 latched writes
    wr(GCTL, 32'd0, 4'b0001);
    wait_active(1'b0, n);
    wr(GCTL, 32'd1, 4'b0001);
    repeat (2) @(negedge clk);
    wr(GCTL, 32'd0, 4'b0001);
    wait_active(1'b1, n);
    check("R10 exit completes first", {31'd0, ctl_active}, 32'd1);
    wait_active(1'b0, n);
    check("R10 latched 0 acted on", n, 32'd9);
    bring_up();
    wr(GCTL, 32'd0, 4'b0001);
    wr(GCTL, 32'd1, 4'b0001);
    wait_active(1'b0, n);
    wait_active(1'b1, n);
    check("R10 latched 1 after entry", n, 32'd5);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule